// File: doc/BRIEF.md
# NAND Status Read Sequencer

This block sits inside a NAND flash controller. After each write-type access it can, when software has turned the feature on, query the flash device for its status on its own. It drives the 8-bit flash I/O bus with the command latch and the write and read strobes to issue the read-status command byte. It then samples the status byte the device returns and keeps it in a register the CPU can read.

The stored byte is decoded into three fields: write permission, device ready, and program/erase result. A failed program or erase sets an error flag. The flag stays set until software clears it, and it raises an interrupt when that interrupt is enabled. Software may also ask for a plain status read. That read updates the stored byte, but it never changes the error flag.

Top module: `nand_stat_seq`

## Requirements
- R1: After reset the command latch and the output enable are low, both strobes are high, every register reads 0, `busy` and `irq` are low, and `op_ready` is high.
- R2: An access with `op_kind` 0 (command-mode write) or 1 (sector-mode write) starts a status read only when control bit 0 (address 0, status-read enable) is 1. `op_kind` 2 (other access) never starts one.
- R3: The command phase drives byte 0x70 with `nand_io_oe` and `nand_cle` high. It holds them for one setup cycle, `PULSE_W` cycles with `nand_we_n` low, and one hold cycle.
- R4: After `GAP_W` idle cycles the status phase holds `nand_cle` and `nand_io_oe` low and pulls `nand_re_n` low for `PULSE_W` cycles. The byte on `nand_io_in` is latched at the edge where `nand_re_n` rises.
- R5: Address 1 returns the latched status byte. Address 2 returns bit 2 = status bit 6 (1 ready, 0 busy) and bit 1 = status bit 7 (1 writable, 0 protected).
- R6: When a status read started by a write latches a byte with bit 0 = 1 (fail), the error flag (address 2 bit 0) becomes 1. A pass leaves it unchanged.
- R7: The error flag stays set through later passing reads and through writes of 0. Writing 1 to address 2 bit 0 clears it.
- R8: `irq` equals the error flag ANDed with control bit 1 (address 0, interrupt enable).
- R9: `busy` is high for exactly 3 + 2*`PULSE_W` + `GAP_W` cycles per status read, and `done` is high for exactly one of them. `op_ready` is low during that time, and requests arriving then are ignored.
- R10: `op_kind` 3 starts a status read whatever the enable bit is, updates the status byte, and leaves the error flag untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 status, 2 flags) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on `reg_addr` |
| op_valid | input | 1 | Access notification valid |
| op_kind | input | 2 | 0 command write, 1 sector write, 2 other, 3 status only |
| op_ready | output | 1 | High when a notification would be accepted |
| busy | output | 1 | Status read in progress |
| done | output | 1 | One-cycle pulse once the status byte is latched |
| irq | output | 1 | Status error interrupt |
| nand_io_out | output | 8 | Flash I/O bus output data |
| nand_io_oe | output | 1 | Flash I/O bus output enable |
| nand_io_in | input | 8 | Flash I/O bus input data |
| nand_cle | output | 1 | Command latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |

## Verification
The bench builds the block with `PULSE_W` = 3 and `GAP_W` = 2, not with the defaults. The strobe widths, the idle gap and the expected busy length of 11 cycles are then all different numbers. An off-by-one in any one phase therefore shows up as a distinct count. The flash model drives the status byte only while the read strobe is low, so a byte latched at the wrong edge reads back as a filler value.

// File: rtl/nss_pkg.sv
package nss_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_CSET  = 3'd1,
    S_CLOW  = 3'd2,
    S_CHOLD = 3'd3,
    S_GAP   = 3'd4,
    S_RLOW  = 3'd5,
    S_DONE  = 3'd6
  } seq_st_t;

  localparam logic [7:0] CMD_READ_STATUS = 8'h70;

  localparam logic [1:0] OP_CMD_WR  = 2'd0;
  localparam logic [1:0] OP_SEC_WR  = 2'd1;
  localparam logic [1:0] OP_OTHER   = 2'd2;
  localparam logic [1:0] OP_STATUS  = 2'd3;

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_STAT  = 2'd1;
  localparam logic [1:0] A_FLAGS = 2'd2;

  function automatic logic st_fail(input logic [7:0] b);
    return b[0];
  endfunction

  function automatic logic st_ready(input logic [7:0] b);
    return b[6];
  endfunction

  function automatic logic st_writable(input logic [7:0] b);
    return b[7];
  endfunction

  function automatic logic [7:0] flags_byte(input logic err, input logic [7:0] b);
    return {5'b0, st_ready(b), st_writable(b), err};
  endfunction

  function automatic int busy_cycles(input int pw, input int gap);
    return 3 + 2 * pw + gap;
  endfunction

endpackage

// File: rtl/nss_timer.sv
module nss_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/nss_fsm.sv
module nss_fsm
  import nss_pkg::*;
#(
  parameter int PULSE_W = 2,
  parameter int GAP_W   = 1,
  parameter int CW      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_eval,
  input  logic          tmr_exp,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          cap_en,
  output logic          cap_eval,
  output logic          busy,
  output logic          done,
  output logic          nand_cle,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic          nand_io_oe,
  output logic [7:0]    nand_io_out
);
  seq_st_t st_q, st_d;
  logic    eval_q;
  logic    cmd_phase;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st_q)
      S_IDLE:  if (start) st_d = S_CSET;
      S_CSET:  begin
        st_d     = S_CLOW;
        tmr_load = 1'b1;
        tmr_val  = CW'(PULSE_W - 1);
      end
      S_CLOW:  if (tmr_exp) st_d = S_CHOLD;
      S_CHOLD: begin
        st_d     = S_GAP;
        tmr_load = 1'b1;
        tmr_val  = CW'(GAP_W - 1);
      end
      S_GAP:   if (tmr_exp) begin
        st_d     = S_RLOW;
        tmr_load = 1'b1;
        tmr_val  = CW'(PULSE_W - 1);
      end
      S_RLOW:  if (tmr_exp) st_d = S_DONE;
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      eval_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE && start) eval_q <= start_eval;
    end
  end

  assign cmd_phase   = (st_q == S_CSET) || (st_q == S_CLOW) || (st_q == S_CHOLD);
  assign nand_cle    = cmd_phase;
  assign nand_io_oe  = cmd_phase;
  assign nand_io_out = cmd_phase ? CMD_READ_STATUS : 8'h00;
  assign nand_we_n   = (st_q != S_CLOW);
  assign nand_re_n   = (st_q != S_RLOW);
  assign cap_en      = (st_q == S_RLOW) && tmr_exp;
  assign cap_eval    = eval_q;
  assign busy        = (st_q != S_IDLE);
  assign done        = (st_q == S_DONE);

  // R3: the write strobe rises with the command byte still latched
  assert_cmd_on_we_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> (nand_cle && nand_io_oe && nand_io_out == CMD_READ_STATUS));

  // R4: reading never overlaps command drive or the write strobe
  assert_read_bus_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> (!nand_cle && !nand_io_oe && nand_we_n));

  // R9: done is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: an accepted start always leads into a busy sequence
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

// File: rtl/nss_regs.sv
module nss_regs
  import nss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       cap_en,
  input  logic       cap_eval,
  input  logic [7:0] cap_byte,
  output logic       stat_en,
  output logic       irq_en,
  output logic       err,
  output logic       err_set,
  output logic       err_clr
);
  logic [7:0] stat_q;

  assign err_set = cap_en && cap_eval && st_fail(cap_byte);
  assign err_clr = reg_we && (reg_addr == A_FLAGS) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_en <= 1'b0;
      irq_en  <= 1'b0;
      stat_q  <= 8'h00;
      err     <= 1'b0;
    end else begin
      if (reg_we && reg_addr == A_CTRL) begin
        stat_en <= reg_wdata[0];
        irq_en  <= reg_wdata[1];
      end
      if (cap_en) stat_q <= cap_byte;
      if (err_set)      err <= 1'b1;
      else if (err_clr) err <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {6'b0, irq_en, stat_en};
      A_STAT:  reg_rdata = stat_q;
      A_FLAGS: reg_rdata = flags_byte(err, stat_q);
      default: reg_rdata = 8'h00;
    endcase
  end

  // R7: the flag holds unless software clears it
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err);

  // R6: the flag only rises from a write-triggered capture
  assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(cap_en && cap_eval));
endmodule

// File: rtl/nand_stat_seq.sv
module nand_stat_seq
  import nss_pkg::*;
#(
  parameter int PULSE_W = 2,
  parameter int GAP_W   = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       op_valid,
  input  logic [1:0] op_kind,
  output logic       op_ready,
  output logic       busy,
  output logic       done,
  output logic       irq,
  output logic [7:0] nand_io_out,
  output logic       nand_io_oe,
  input  logic [7:0] nand_io_in,
  output logic       nand_cle,
  output logic       nand_we_n,
  output logic       nand_re_n
);
  localparam int MAXW = (PULSE_W > GAP_W) ? PULSE_W : GAP_W;
  localparam int CW   = $clog2(MAXW + 1);

  logic          start, start_eval;
  logic          stat_en, irq_en, err, err_set, err_clr;
  logic          tmr_load, tmr_exp;
  logic [CW-1:0] tmr_val;
  logic          cap_en, cap_eval;

  assign start      = op_valid && !busy &&
                      ((op_kind == OP_STATUS) || (!op_kind[1] && stat_en));
  assign start_eval = !op_kind[1];
  assign op_ready   = !busy;
  assign irq        = err && irq_en;

  nss_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  nss_fsm #(.PULSE_W(PULSE_W), .GAP_W(GAP_W), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .start_eval(start_eval),
    .tmr_exp(tmr_exp), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .cap_en(cap_en), .cap_eval(cap_eval), .busy(busy), .done(done),
    .nand_cle(nand_cle), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_io_oe(nand_io_oe), .nand_io_out(nand_io_out)
  );

  nss_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_en(cap_en),
    .cap_eval(cap_eval), .cap_byte(nand_io_in), .stat_en(stat_en),
    .irq_en(irq_en), .err(err), .err_set(err_set), .err_clr(err_clr)
  );

  // R8: an interrupt implies a pending error
  assert_irq_needs_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> err);

  // R9: captures only happen inside a busy sequence
  assert_cap_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> (busy && !done));
endmodule

// File: tb/nand_stat_seq_tb.sv
module nand_stat_seq_tb;
  localparam int PW  = 3;
  localparam int GW  = 2;
  localparam int EXP_BUSY = 3 + 2 * PW + GW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       op_valid = 1'b0;
  logic [1:0] op_kind = 2'd0;
  logic       op_ready, busy, done, irq;
  logic [7:0] nand_io_out, nand_io_in;
  logic       nand_io_oe, nand_cle, nand_we_n, nand_re_n;
  logic [7:0] flash_stat = 8'h00;

  int n_chk = 0;
  int n_bad = 0;

  logic mon = 1'b0;
  int busy_n, done_n, we_lo, re_lo, we_pulses, cmd_bad, rd_bad;
  logic prev_we = 1'b1;

  always #2 clk = ~clk;

  assign nand_io_in = nand_re_n ? 8'hEE : flash_stat;

  nand_stat_seq #(.PULSE_W(PW), .GAP_W(GW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .op_valid(op_valid),
    .op_kind(op_kind), .op_ready(op_ready), .busy(busy), .done(done),
    .irq(irq), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .nand_io_in(nand_io_in), .nand_cle(nand_cle), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n)
  );

  always @(negedge clk) begin
    if (mon) begin
      if (busy) busy_n++;
      if (done) done_n++;
      if (!nand_we_n) begin
        we_lo++;
        if (!(nand_cle && nand_io_oe && nand_io_out == 8'h70)) cmd_bad++;
        if (prev_we) we_pulses++;
      end
      if (!nand_re_n) begin
        re_lo++;
        if (nand_cle || nand_io_oe) rd_bad++;
      end
    end
    prev_we <= nand_we_n;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run_op(input logic [1:0] kind, input logic [7:0] stat, input bit poke);
    busy_n = 0; done_n = 0; we_lo = 0; re_lo = 0; we_pulses = 0; cmd_bad = 0; rd_bad = 0;
    flash_stat = stat;
    @(negedge clk);
    mon = 1'b1;
    op_valid = 1'b1; op_kind = kind;
    @(negedge clk);
    op_valid = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      chk("R9 op_ready low while busy", int'(op_ready), 0);
      op_valid = 1'b1; op_kind = 2'd3;
      repeat (2) @(negedge clk);
      op_valid = 1'b0;
    end
    for (int i = 0; i < 60; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    mon = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 cle", int'(nand_cle), 0);
    chk("R1 oe", int'(nand_io_oe), 0);
    chk("R1 we_n", int'(nand_we_n), 1);
    chk("R1 re_n", int'(nand_re_n), 1);
    chk("R1 busy", int'(busy), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 op_ready", int'(op_ready), 1);
    for (int a = 0; a < 3; a++) begin
      reg_read(2'(a), d);
      chk("R1 register zero", int'(d), 0);
    end
  endtask

  task automatic t_no_trigger();
    reg_write(2'd0, 8'h00);
    run_op(2'd0, 8'hC0, 1'b0);
    chk("R2 disabled write no busy", busy_n, 0);
    chk("R2 disabled write no strobe", we_lo, 0);
    reg_write(2'd0, 8'h01);
    run_op(2'd2, 8'hC0, 1'b0);
    chk("R2 other access no busy", busy_n, 0);
    chk("R2 other access no read", re_lo, 0);
  endtask

  task automatic t_write_pass();
    logic [7:0] d;
    reg_write(2'd0, 8'h01);
    run_op(2'd0, 8'hC0, 1'b0);
    chk("R3 we low width", we_lo, PW);
    chk("R3 command byte and cle", cmd_bad, 0);
    chk("R4 re low width", re_lo, PW);
    chk("R4 bus released in read", rd_bad, 0);
    chk("R9 busy length", busy_n, EXP_BUSY);
    chk("R9 done once", done_n, 1);
    reg_read(2'd1, d);
    chk("R5 status byte", int'(d), 8'hC0);
    reg_read(2'd2, d);
    chk("R5 flags ready+writable", int'(d), 8'h06);
    chk("R8 irq quiet on pass", int'(irq), 0);
  endtask

  task automatic t_write_fail();
    logic [7:0] d;
    run_op(2'd1, 8'h41, 1'b0);
    reg_read(2'd1, d);
    chk("R4 sampled byte", int'(d), 8'h41);
    reg_read(2'd2, d);
    chk("R6 error set, protected", int'(d), 8'h05);
    chk("R8 irq masked", int'(irq), 0);
    reg_write(2'd0, 8'h03);
    @(negedge clk);
    chk("R8 irq enabled", int'(irq), 1);
  endtask

  task automatic t_sticky();
    logic [7:0] d;
    run_op(2'd0, 8'hC0, 1'b0);
    reg_read(2'd2, d);
    chk("R7 error survives pass", int'(d), 8'h07);
    reg_write(2'd2, 8'h00);
    reg_read(2'd2, d);
    chk("R7 write zero keeps error", int'(d[0]), 1);
    reg_write(2'd2, 8'h01);
    reg_read(2'd2, d);
    chk("R7 write one clears", int'(d[0]), 0);
    chk("R8 irq drops", int'(irq), 0);
  endtask

  task automatic t_explicit();
    logic [7:0] d;
    reg_write(2'd0, 8'h02);
    run_op(2'd3, 8'h01, 1'b0);
    chk("R10 status-only runs", busy_n, EXP_BUSY);
    reg_read(2'd1, d);
    chk("R10 byte stored", int'(d), 8'h01);
    reg_read(2'd2, d);
    chk("R10 error untouched", int'(d), 8'h00);
    chk("R10 no irq", int'(irq), 0);
  endtask

  task automatic t_holdoff();
    reg_write(2'd0, 8'h01);
    run_op(2'd0, 8'hC0, 1'b1);
    chk("R9 single command pulse", we_pulses, 1);
    chk("R9 busy not extended", busy_n, EXP_BUSY);
    chk("R9 single done", done_n, 1);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_trigger();
    t_write_pass();
    t_write_fail();
    t_sticky();
    t_explicit();
    t_holdoff();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule